// File: doc/BRIEF.md
# Program Counter Sequencing Unit

This block holds the instruction address of a small microcontroller core whose fetch of one word overlaps the execution of the word before it. Once per instruction cycle, signalled by a single-cycle enable pulse that arrives every four system clocks, it picks the next fetch address. The candidates are the incremented counter, a fixed interrupt vector, a popped return address, a jump or call target, a new low byte with the page bits kept, or a skip past the prefetched word.

Every source other than the plain increment leaves an already-fetched word that must not run. The block raises a bubble flag for the following instruction cycle so that the decoder executes a dummy no-op in that word's place. When an interrupt is taken, the block offers the address of the next unexecuted instruction on a push strobe for the external stack. The block does not contain the decoder, the program ROM, the stack storage or the interrupt masking.

Top module: `pc_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `fetch_addr` becomes 0x000 and `bubble` becomes 1, whatever the other inputs are. `push_stb` is 0 while `rst_n` is low.
- R2: At an edge where `cyc_en` is 0, `fetch_addr` and `bubble` keep their values, whatever requests are present.
- R3: With `cyc_en` high and no request present, `fetch_addr` advances by one at the edge, and 0x3FF wraps to 0x000.
- R4: An interrupt taken on `irq_req` bit k loads `fetch_addr` with 4*(k+1), giving 0x004, 0x008, 0x00C and 0x010 for bits 0 to 3. When several bits are set, the lowest set bit wins.
- R5: `push_stb` is high exactly in cycles where `rst_n`, `cyc_en` and at least one `irq_req` bit are high. In those cycles `push_addr` equals the current `fetch_addr`.
- R6: A low-byte write loads `fetch_addr[7:0]` with `lowb_data` and keeps `fetch_addr[9:8]`.
- R7: A jump or call loads all 10 bits of `fetch_addr` from `jmp_tgt`.
- R8: A return loads all 10 bits of `fetch_addr` from `ret_addr`.
- R9: A taken skip sets `fetch_addr` to the current value plus one, with wrap. This address lies two words past the skipping instruction.
- R10: After an enabled edge, `bubble` is 1 if that edge took an interrupt, return, jump, low-byte write or skip. It is 0 if the edge made a plain increment.
- R11: When several requests are present at one enabled edge, the priority from highest to lowest is interrupt, return, jump, low-byte write, skip, increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_en | input | 1 | One-cycle pulse per instruction cycle |
| irq_req | input | 4 | Pending interrupt requests, bit 0 has the highest priority |
| skip_req | input | 1 | Conditional skip taken |
| lowb_wr | input | 1 | Write to the counter's low byte |
| lowb_data | input | 8 | Value for the low byte |
| jmp_req | input | 1 | Jump or call |
| jmp_tgt | input | 10 | Jump or call target |
| ret_req | input | 1 | Return from subroutine |
| ret_addr | input | 10 | Address popped from the stack |
| fetch_addr | output | 10 | Address of the word being fetched |
| bubble | output | 1 | The current prefetched word is to be executed as a no-op |
| push_stb | output | 1 | Push the return address onto the stack |
| push_addr | output | 10 | Return address to push |

## Verification
Any two of the redirect sources can fall in the same instruction cycle. The most telling pairs are an interrupt arriving with a return or jump, and a low-byte write arriving with a skip. The bench drives all 32 combinations of interrupt, return, jump, low-byte write and skip at once, using distinct target values so that each source leaves a different address. It compares the next fetch address and the bubble flag with a priority model computed in the bench. It also checks that the push strobe fires only when an interrupt is among the active requests.

// File: rtl/pc_seq_pkg.sv
// Shared types of the program counter sequencing unit.
package pc_seq_pkg;

    // Source chosen for the next fetch address, listed from highest to lowest priority.
    typedef enum logic [2:0] {
        SRC_IRQ  = 3'd0,
        SRC_RET  = 3'd1,
        SRC_JMP  = 3'd2,
        SRC_LOWB = 3'd3,
        SRC_SKIP = 3'd4,
        SRC_INC  = 3'd5
    } pc_src_e;

endpackage

// File: rtl/pc_irq_vec.sv
// Interrupt vector encoder.
// Maps the lowest set request bit k to the address (k+1)*VEC_STRIDE.
// Assumes that (NUM_IRQ)*VEC_STRIDE fits in ADDR_W bits.
module pc_irq_vec #(
    parameter int ADDR_W     = 10,
    parameter int NUM_IRQ    = 4,
    parameter int VEC_STRIDE = 4
) (
    input  logic [NUM_IRQ-1:0] irq_req,
    output logic               irq_any,
    output logic [ADDR_W-1:0]  irq_vec
);

    // Any pending request at all.
    assign irq_any = |irq_req;

    // Scan from the top so that the lowest set bit is the last one written.
    always_comb begin
        irq_vec = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (irq_req[i]) begin
                irq_vec = ADDR_W'((i + 1) * VEC_STRIDE);
            end
        end
    end

endmodule

// File: rtl/pc_src_sel.sv
// Priority selector for the next-address source.
// Order: interrupt, return, jump/call, low-byte write, skip, increment.
// Reset is not handled here; the counter register applies it directly.
module pc_src_sel
    import pc_seq_pkg::*;
(
    input  logic    irq_any,
    input  logic    ret_req,
    input  logic    jmp_req,
    input  logic    lowb_wr,
    input  logic    skip_req,
    output pc_src_e src,
    output logic    discard
);

    // Fixed priority chain.
    always_comb begin
        if (irq_any)       src = SRC_IRQ;
        else if (ret_req)  src = SRC_RET;
        else if (jmp_req)  src = SRC_JMP;
        else if (lowb_wr)  src = SRC_LOWB;
        else if (skip_req) src = SRC_SKIP;
        else               src = SRC_INC;
    end

    // Every source except the plain increment throws away the prefetched word.
    assign discard = (src != SRC_INC);

endmodule

// File: rtl/pc_next_mux.sv
// Next fetch address multiplexer.
// Builds each candidate address and selects one by source.
// The low-byte write replaces only the low LOW_W bits and keeps the page.
module pc_next_mux
    import pc_seq_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LOW_W  = 8
) (
    input  pc_src_e           src,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] irq_vec,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic [ADDR_W-1:0] jmp_tgt,
    input  logic [LOW_W-1:0]  lowb_data,
    output logic [ADDR_W-1:0] pc_next
);

    localparam int PAGE_W = ADDR_W - LOW_W;

    logic [ADDR_W-1:0] pc_inc;
    logic [ADDR_W-1:0] pc_lowb;

    // Increment with natural wrap at the top of memory; a skip uses the same value.
    assign pc_inc = pc + ADDR_W'(1);

    // Low-byte write address; the page bits exist only if the counter is wider than the byte.
    generate
        if (PAGE_W > 0) begin : g_paged
            assign pc_lowb = {pc[ADDR_W-1:LOW_W], lowb_data};
        end else begin : g_flat
            assign pc_lowb = lowb_data[ADDR_W-1:0];
        end
    endgenerate

    // Source selection.
    always_comb begin
        case (src)
            SRC_IRQ:  pc_next = irq_vec;
            SRC_RET:  pc_next = ret_addr;
            SRC_JMP:  pc_next = jmp_tgt;
            SRC_LOWB: pc_next = pc_lowb;
            SRC_SKIP: pc_next = pc_inc;
            default:  pc_next = pc_inc;
        endcase
    end

endmodule

// File: rtl/pc_seq.sv
// Program counter sequencing unit, top level.
// Holds the fetch address of a two-stage fetch/execute pipeline and
// updates it once per instruction cycle when cyc_en pulses.
// Assumes that cyc_en is a one-clock pulse and that rst_n is synchronous.
module pc_seq
    import pc_seq_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int LOW_W      = 8,
    parameter int NUM_IRQ    = 4,
    parameter int VEC_STRIDE = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_en,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               skip_req,
    input  logic               lowb_wr,
    input  logic [LOW_W-1:0]   lowb_data,
    input  logic               jmp_req,
    input  logic [ADDR_W-1:0]  jmp_tgt,
    input  logic               ret_req,
    input  logic [ADDR_W-1:0]  ret_addr,
    output logic [ADDR_W-1:0]  fetch_addr,
    output logic               bubble,
    output logic               push_stb,
    output logic [ADDR_W-1:0]  push_addr
);

    logic [ADDR_W-1:0] pc_q;
    logic              bubble_q;
    logic              irq_any;
    logic [ADDR_W-1:0] irq_vec;
    pc_src_e           src;
    logic              discard;
    logic [ADDR_W-1:0] pc_next;

    pc_irq_vec #(
        .ADDR_W    (ADDR_W),
        .NUM_IRQ   (NUM_IRQ),
        .VEC_STRIDE(VEC_STRIDE)
    ) u_vec (
        .irq_req(irq_req),
        .irq_any(irq_any),
        .irq_vec(irq_vec)
    );

    pc_src_sel u_sel (
        .irq_any (irq_any),
        .ret_req (ret_req),
        .jmp_req (jmp_req),
        .lowb_wr (lowb_wr),
        .skip_req(skip_req),
        .src     (src),
        .discard (discard)
    );

    pc_next_mux #(
        .ADDR_W(ADDR_W),
        .LOW_W (LOW_W)
    ) u_mux (
        .src      (src),
        .pc       (pc_q),
        .irq_vec  (irq_vec),
        .ret_addr (ret_addr),
        .jmp_tgt  (jmp_tgt),
        .lowb_data(lowb_data),
        .pc_next  (pc_next)
    );

    // Counter and bubble flag: reset to the zero vector, update only on the cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            bubble_q <= 1'b1;
        end else if (cyc_en) begin
            pc_q     <= pc_next;
            bubble_q <= discard;
        end
    end

    // Interrupt entry pushes the address of the word not yet executed, which is the one being fetched.
    assign push_stb   = rst_n & cyc_en & irq_any;
    assign push_addr  = pc_q;
    assign fetch_addr = pc_q;
    assign bubble     = bubble_q;

endmodule

// File: rtl/pc_seq_chk.sv
// Property checker for pc_seq, attached with bind.
module pc_seq_chk #(
    parameter int ADDR_W  = 10,
    parameter int LOW_W   = 8,
    parameter int NUM_IRQ = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cyc_en,
    input logic [NUM_IRQ-1:0] irq_req,
    input logic               skip_req,
    input logic               lowb_wr,
    input logic               jmp_req,
    input logic               ret_req,
    input logic [ADDR_W-1:0]  ret_addr,
    input logic [ADDR_W-1:0]  fetch_addr,
    input logic               bubble,
    input logic               push_stb,
    input logic [ADDR_W-1:0]  push_addr
);

    logic any_req;
    assign any_req = (|irq_req) | skip_req | lowb_wr | jmp_req | ret_req;

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_en |=> ($stable(fetch_addr) && $stable(bubble)));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && !any_req) |=> (fetch_addr == $past(fetch_addr) + ADDR_W'(1)) && !bubble);

    p_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push_stb |-> (cyc_en && (|irq_req) && push_addr == fetch_addr));

    p_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && lowb_wr && !(|irq_req) && !ret_req && !jmp_req)
        |=> fetch_addr[ADDR_W-1:LOW_W] == $past(fetch_addr[ADDR_W-1:LOW_W]));

    p_bubble_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && any_req) |=> bubble);

    p_ret_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && ret_req && !(|irq_req)) |=> fetch_addr == $past(ret_addr));

endmodule

bind pc_seq pc_seq_chk #(
    .ADDR_W (ADDR_W),
    .LOW_W  (LOW_W),
    .NUM_IRQ(NUM_IRQ)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_en    (cyc_en),
    .irq_req   (irq_req),
    .skip_req  (skip_req),
    .lowb_wr   (lowb_wr),
    .jmp_req   (jmp_req),
    .ret_req   (ret_req),
    .ret_addr  (ret_addr),
    .fetch_addr(fetch_addr),
    .bubble    (bubble),
    .push_stb  (push_stb),
    .push_addr (push_addr)
);

// File: tb/tb_pc_seq.sv
module tb_pc_seq;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cyc_en;
    logic [3:0] irq_req;
    logic       skip_req;
    logic       lowb_wr;
    logic [7:0] lowb_data;
    logic       jmp_req;
    logic [9:0] jmp_tgt;
    logic       ret_req;
    logic [9:0] ret_addr;
    logic [9:0] fetch_addr;
    logic       bubble;
    logic       push_stb;
    logic [9:0] push_addr;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;
    logic [9:0] exp_pc;
    logic       exp_bub;

    always #4 clk = ~clk;

    pc_seq dut (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .irq_req(irq_req),
        .skip_req(skip_req), .lowb_wr(lowb_wr), .lowb_data(lowb_data),
        .jmp_req(jmp_req), .jmp_tgt(jmp_tgt), .ret_req(ret_req),
        .ret_addr(ret_addr), .fetch_addr(fetch_addr), .bubble(bubble),
        .push_stb(push_stb), .push_addr(push_addr)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    task automatic idle_inputs();
        cyc_en = 1'b1; irq_req = '0; skip_req = 0; lowb_wr = 0; lowb_data = '0;
        jmp_req = 0; jmp_tgt = '0; ret_req = 0; ret_addr = '0;
    endtask

    // Priority model written from the requirements.
    task automatic model();
        bit any = 1'b0;
        if (irq_req != 0) begin
            for (int k = 3; k >= 0; k--) if (irq_req[k]) exp_pc = 10'((k + 1) * 4);
        end else if (ret_req)  exp_pc = ret_addr;
        else if (jmp_req)      exp_pc = jmp_tgt;
        else if (lowb_wr)      exp_pc = {exp_pc[9:8], lowb_data};
        else                   exp_pc = exp_pc + 10'd1;
        any = (irq_req != 0) | ret_req | jmp_req | lowb_wr | skip_req;
        exp_bub = any;
    endtask

    // Inputs are already driven after a falling edge; clock one instruction cycle and sample.
    task automatic step();
        if (cyc_en) model();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_state(input string tag);
        check(fetch_addr == exp_pc, {tag, " fetch_addr"}, fetch_addr, exp_pc);
        check(bubble == exp_bub, {tag, " bubble"}, bubble, exp_bub);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        jmp_req = 1; jmp_tgt = 10'h2AA; irq_req = 4'h3;
        @(negedge clk);
        check(push_stb == 0, "R1 push_stb in reset", push_stb, 0);
        @(posedge clk); @(negedge clk);
        exp_pc = 0; exp_bub = 1;
        chk_state("R1 reset");
        idle_inputs();
        rst_n = 1'b1;

        // R3: full sweep of the increment, including the wrap from 0x3FF.
        for (int i = 0; i < 1024; i++) begin
            step();
            chk_state("R3 increment");
        end
        check(fetch_addr == 10'h000, "R3 wrap back to zero", fetch_addr, 0);

        // R2: requests are ignored while cyc_en is low.
        cyc_en = 0; jmp_req = 1; jmp_tgt = 10'h155; irq_req = 4'hF; skip_req = 1;
        for (int i = 0; i < 3; i++) begin
            step();
            chk_state("R2 hold without enable");
        end
        check(push_stb == 0, "R2 no push without enable", push_stb, 0);
        idle_inputs();

        // R4, R5: every interrupt pattern.
        for (int m = 1; m < 16; m++) begin
            jmp_req = 1; jmp_tgt = 10'(37 * m);
            step();
            idle_inputs();
            irq_req = 4'(m);
            #1;
            check(push_stb == 1, "R5 push_stb", push_stb, 1);
            check(push_addr == exp_pc, "R5 push_addr", push_addr, exp_pc);
            step();
            chk_state("R4 vector / R10");
            idle_inputs();
            #1;
            check(push_stb == 0, "R5 no push without interrupt", push_stb, 0);
            step();
            chk_state("R10 bubble clears");
        end

        // R6, R7: every low byte on every page.
        for (int pg = 0; pg < 4; pg++) begin
            jmp_req = 1; jmp_tgt = 10'(pg * 256 + 5);
            step();
            chk_state("R7 jump");
            idle_inputs();
            for (int v = 0; v < 256; v++) begin
                lowb_wr = 1; lowb_data = 8'(v);
                step();
                chk_state("R6 low byte write");
            end
            idle_inputs();
        end

        // R8: return loads the popped value.
        for (int i = 0; i < 8; i++) begin
            ret_req = 1; ret_addr = 10'(i * 131 + 7);
            step();
            chk_state("R8 return");
        end
        idle_inputs();

        // R9: skip goes two past the skipping word, also across the top.
        jmp_req = 1; jmp_tgt = 10'h3FE;
        step();
        idle_inputs();
        skip_req = 1;
        step();
        check(fetch_addr == 10'h3FF, "R9 skip", fetch_addr, 10'h3FF);
        check(bubble == 1, "R9 skip bubble", bubble, 1);
        step();
        check(fetch_addr == 10'h000, "R9 skip wrap", fetch_addr, 0);
        idle_inputs();

        // R11: all combinations of competing requests.
        for (int c = 0; c < 32; c++) begin
            jmp_req = 1; jmp_tgt = 10'h0F0;
            step();
            idle_inputs();
            irq_req   = c[0] ? 4'b0100 : 4'b0000;
            ret_req   = c[1]; ret_addr  = 10'h2C3;
            jmp_req   = c[2]; jmp_tgt   = 10'h1A9;
            lowb_wr   = c[3]; lowb_data = 8'h5E;
            skip_req  = c[4];
            #1;
            check(push_stb == c[0], "R11 push only with interrupt", push_stb, c[0]);
            step();
            chk_state("R11 priority");
            idle_inputs();
        end

        // R1: reset in mid-run overrides a jump.
        jmp_req = 1; jmp_tgt = 10'h123; rst_n = 0;
        @(posedge clk); @(negedge clk);
        exp_pc = 0; exp_bub = 1;
        chk_state("R1 reset mid-run");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule